// File: doc/BRIEF.md
# Double-Buffered Clock Generator Configuration Bank

This block holds the configuration of a clock-generator controller and presents it to the datapath as decoded fields. A host reaches it through a plain parallel register port: an 8-bit address, write data with a write strobe, and a read strobe that returns data on the following cycle. The analog loop, delay line and dividers are not part of the block. It only drives their settings and receives their two lock indications.

Some settings must not change while their subsystem is running. For these the host writes a staging copy, and the copy that drives the datapath does not change. A coded byte written to a write-only command address then moves the staged values into the live copies and sends a one-cycle reset pulse to the matching subsystem. The loop-divider group and the delay-aligner group have separate codes, and one byte can carry both codes. The remaining settings take effect as soon as they are written. Identification bytes and live lock status can be read.

Top module: `cfg_bank`

## Requirements
- R1: After reset the live outputs are: control byte 0x41, `fb_div_o` 0xFFF, `pd_gain_o` 0, `post_div_o` 0, `dly_res_o` 3, `out_en_o` 0x1F, `clk_sel_o` 0, `out_scale_o` 0, `phase_ofs_o` 0, `filt_int_o` 1, `osc_div_o` 0, and both reset pulses low. Reads of 0x00, 0x03 and 0x06 return 0x41, 0x0F and 0x1F.
- R2: Writes to 0x01, 0x02, 0x03 and 0x05 change only the staging copy, and reads of those addresses return the staged value. The live outputs keep their value until the matching commit.
- R3: A write to 0x08 whose bits 7:4 equal 0x5 loads the live copies of 0x01 to 0x03 from their staged values at that clock edge. `pll_rst_o` is then high for exactly one cycle.
- R4: A write to 0x08 whose bits 3:0 equal 0xA loads the live copy of 0x05 at that clock edge. `dly_rst_o` is then high for exactly one cycle.
- R5: A command byte that matches both codes (0x5A) performs both commits and both pulses together. A byte that matches neither code (such as 0xA5) changes nothing and raises no pulse.
- R6: Addresses 0x00, 0x04, 0x06 and 0x07 drive their outputs directly, and the new value shows on the outputs at the clock edge that takes the write. Address 0x06 maps bits 4:0 to `out_en_o`, bit 5 to `clk_sel_o` and bits 7:6 to `out_scale_o`. Address 0x04 maps bits 5:0 to `phase_ofs_o` and bit 7 to `filt_int_o`. Address 0x01 maps bits 2:0 to `pd_gain_o` and bits 5:4 to `post_div_o`. Address 0x05 maps bits 1:0 to `dly_res_o`. Address 0x07 maps bits 6:0 to `osc_div_o`.
- R7: Reserved bits ignore writes and read back as 0. These are bit 3 and bits 7:6 of 0x01, bits 7:4 of 0x03, bit 6 of 0x04, bits 7:2 of 0x05 and bit 7 of 0x07.
- R8: A read of 0x12 returns the live lock inputs as they are at the read edge: `dly_lock_i` in bit 0, `pll_lock_i` in bit 1, and 0 in bits 7:2.
- R9: Reads of 0x10 and 0x11 return the parameters `VER_ID` and `REV_ID`. Writes to those addresses have no effect.
- R10: Reads of 0x08 and of unmapped addresses return 0x00. Writes to unmapped addresses change no register.
- R11: `rdata_o` is updated at the clock edge where `re_i` is high. It holds its value while `re_i` is low, even when the lock inputs change.
- R12: `fb_div_o` is 12 bits wide. Bits 7:0 come from address 0x02 and bits 11:8 come from bits 3:0 of address 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| pll_lock_i | input | 1 | Loop lock indication |
| dly_lock_i | input | 1 | Delay aligner lock indication |
| ctrl_o | output | 8 | Control byte from 0x00 |
| pd_gain_o | output | 3 | Live detector gain |
| post_div_o | output | 2 | Live post-scaler select |
| fb_div_o | output | 12 | Live feedback divide value |
| phase_ofs_o | output | 6 | Aligner phase offset |
| filt_int_o | output | 1 | Loop filter select |
| dly_res_o | output | 2 | Live aligner resolution |
| out_en_o | output | 5 | Output enables |
| clk_sel_o | output | 1 | Clock source select |
| out_scale_o | output | 2 | Output scaler |
| osc_div_o | output | 7 | Oscillator divider modulus |
| pll_rst_o | output | 1 | One-cycle loop reset pulse |
| dly_rst_o | output | 1 | One-cycle aligner reset pulse |

## Verification
The bench builds the block with `VER_ID` set to 0xA7 and `REV_ID` set to 0x3C instead of the defaults. A design that hard-wires its identification bytes therefore returns the wrong value on the identification reads. The data patterns are chosen so that every reserved bit is written with a 1, and each commit group is staged with values that differ from its reset contents. A commit that picks the wrong group, or that also loads the other group, then shows on the outputs.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int AW     = 8;
  localparam int DW     = 8;
  localparam int NUM_RW = 8;

  typedef enum logic [1:0] {GRP_NONE, GRP_PLL, GRP_DLY} grp_e;

  localparam logic [AW-1:0] ADDR_CMD  = 8'h08;
  localparam logic [AW-1:0] ADDR_VER  = 8'h10;
  localparam logic [AW-1:0] ADDR_REV  = 8'h11;
  localparam logic [AW-1:0] ADDR_LOCK = 8'h12;

  localparam logic [3:0] CODE_PLL = 4'h5;
  localparam logic [3:0] CODE_DLY = 4'hA;

  function automatic logic [DW-1:0] rw_rst(input int i);
    case (i)
      0:       return 8'h41;
      2:       return 8'hFF;
      3:       return 8'h0F;
      4:       return 8'h80;
      5:       return 8'h03;
      6:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] rw_mask(input int i);
    case (i)
      1:       return 8'h37;
      3:       return 8'h0F;
      4:       return 8'hBF;
      5:       return 8'h03;
      7:       return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic grp_e rw_grp(input int i);
    case (i)
      1, 2, 3: return GRP_PLL;
      5:       return GRP_DLY;
      default: return GRP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cfg_dbuf_reg.sv
module cfg_dbuf_reg #(
  parameter int          W    = 8,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] MASK = '1,
  parameter bit          DBUF = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         commit_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] work_o
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= RST;
    else if (we_i) shadow_q <= wdata_i & MASK;
  end

  assign shadow_o = shadow_q;

  generate
    if (DBUF) begin : g_dbuf
      logic [W-1:0] work_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       work_q <= RST;
        else if (commit_i) work_q <= shadow_q;
      end
      assign work_o = work_q;

      p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |=> $stable(work_o));
      p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_i |=> work_o == $past(shadow_o));
    end else begin : g_direct
      assign work_o = shadow_q;
    end
  endgenerate

  p_rsvd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (shadow_o & ~MASK) == '0);
endmodule

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pll_go_o,
  output logic          dly_go_o,
  output logic          pll_rst_o,
  output logic          dly_rst_o
);
  logic cmd_wr;
  assign cmd_wr   = we_i && (addr_i == ADDR_CMD);
  assign pll_go_o = cmd_wr && (wdata_i[7:4] == CODE_PLL);
  assign dly_go_o = cmd_wr && (wdata_i[3:0] == CODE_DLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_rst_o <= 1'b0;
      dly_rst_o <= 1'b0;
    end else begin
      pll_rst_o <= pll_go_o;
      dly_rst_o <= dly_go_o;
    end
  end

  p_pll_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |=> !pll_rst_o);
  p_dly_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_rst_o |=> !dly_rst_o);
  p_pll_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_CMD) |=> !pll_rst_o && !dly_rst_o);
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_bank_pkg::*;
#(
  parameter logic [DW-1:0] VER_ID = 8'h17,
  parameter logic [DW-1:0] REV_ID = 8'h02
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     re_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [NUM_RW-1:0][DW-1:0] shadow_i,
  input  logic                     pll_lock_i,
  input  logic                     dly_lock_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr_i < AW'(NUM_RW)) rd_mux = shadow_i[addr_i[$clog2(NUM_RW)-1:0]];
    else if (addr_i == ADDR_VER)  rd_mux = VER_ID;
    else if (addr_i == ADDR_REV)  rd_mux = REV_ID;
    else if (addr_i == ADDR_LOCK) rd_mux = {6'b0, pll_lock_i, dly_lock_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  p_lock_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_LOCK) |=> rdata_o == {6'b0, $past(pll_lock_i), $past(dly_lock_i)});
  p_cmd_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_CMD) |=> rdata_o == '0);
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter logic [7:0] VER_ID = 8'h17,
  parameter logic [7:0] REV_ID = 8'h02
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        we_i,
  input  logic        re_i,
  output logic [7:0]  rdata_o,
  input  logic        pll_lock_i,
  input  logic        dly_lock_i,
  output logic [7:0]  ctrl_o,
  output logic [2:0]  pd_gain_o,
  output logic [1:0]  post_div_o,
  output logic [11:0] fb_div_o,
  output logic [5:0]  phase_ofs_o,
  output logic        filt_int_o,
  output logic [1:0]  dly_res_o,
  output logic [4:0]  out_en_o,
  output logic        clk_sel_o,
  output logic [1:0]  out_scale_o,
  output logic [6:0]  osc_div_o,
  output logic        pll_rst_o,
  output logic        dly_rst_o
);
  logic [NUM_RW-1:0][DW-1:0] shadow, work;
  logic pll_go, dly_go;

  cfg_cmd_decode i_cmd (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .pll_go_o (pll_go),
    .dly_go_o (dly_go),
    .pll_rst_o,
    .dly_rst_o
  );

  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    localparam grp_e GRP = rw_grp(i);
    logic slot_we, slot_commit;
    assign slot_we     = we_i && (addr_i == AW'(i));
    assign slot_commit = (GRP == GRP_PLL) ? pll_go :
                         (GRP == GRP_DLY) ? dly_go : 1'b0;
    cfg_dbuf_reg #(
      .W    (DW),
      .RST  (rw_rst(i)),
      .MASK (rw_mask(i)),
      .DBUF (GRP != GRP_NONE)
    ) i_reg (
      .clk_i, .rst_ni,
      .we_i     (slot_we),
      .wdata_i,
      .commit_i (slot_commit),
      .shadow_o (shadow[i]),
      .work_o   (work[i])
    );
  end

  cfg_read_mux #(.VER_ID(VER_ID), .REV_ID(REV_ID)) i_rd (
    .clk_i, .rst_ni, .re_i, .addr_i,
    .shadow_i (shadow),
    .pll_lock_i, .dly_lock_i,
    .rdata_o
  );

  assign ctrl_o      = work[0];
  assign pd_gain_o   = work[1][2:0];
  assign post_div_o  = work[1][5:4];
  assign fb_div_o    = {work[3][3:0], work[2]};
  assign phase_ofs_o = work[4][5:0];
  assign filt_int_o  = work[4][7];
  assign dly_res_o   = work[5][1:0];
  assign out_en_o    = work[6][4:0];
  assign clk_sel_o   = work[6][5];
  assign out_scale_o = work[6][7:6];
  assign osc_div_o   = work[7][6:0];

  p_fb_commit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_go |=> $stable(fb_div_o));
  p_ctrl_direct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h00) |=> ctrl_o == $past(wdata_i));
endmodule

// File: tb/test_cfg_bank.sv
module test_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic        pll_lock = 1'b0, dly_lock = 1'b0;
  logic [7:0]  rdata, ctrl;
  logic [2:0]  pd_gain;
  logic [1:0]  post_div, dly_res, out_scale;
  logic [11:0] fb_div;
  logic [5:0]  phase_ofs;
  logic        filt_int, clk_sel, pll_rst, dly_rst;
  logic [4:0]  out_en;
  logic [6:0]  osc_div;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_bank #(.VER_ID(8'hA7), .REV_ID(8'h3C)) i_cfg_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata),
    .pll_lock_i(pll_lock), .dly_lock_i(dly_lock),
    .ctrl_o(ctrl), .pd_gain_o(pd_gain), .post_div_o(post_div),
    .fb_div_o(fb_div), .phase_ofs_o(phase_ofs), .filt_int_o(filt_int),
    .dly_res_o(dly_res), .out_en_o(out_en), .clk_sel_o(clk_sel),
    .out_scale_o(out_scale), .osc_div_o(osc_div),
    .pll_rst_o(pll_rst), .dly_rst_o(dly_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  // issues a command byte; samples the pulses on the cycle after and the one after that
  task automatic cmd(input logic [7:0] d, output logic p1, output logic d1,
                     output logic p2, output logic d2);
    @(negedge clk); addr = 8'h08; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; p1 = pll_rst; d1 = dly_rst;
    @(negedge clk); p2 = pll_rst; d2 = dly_rst;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 ctrl", ctrl, 8'h41);
    chk("R1 fb_div", fb_div, 12'hFFF);
    chk("R1 pd_gain", pd_gain, 0);
    chk("R1 post_div", post_div, 0);
    chk("R1 dly_res", dly_res, 3);
    chk("R1 out_en", out_en, 5'h1F);
    chk("R1 clk_sel/scale", {clk_sel, out_scale}, 0);
    chk("R1 phase/filt", {phase_ofs, filt_int}, 7'h01);
    chk("R1 osc_div", osc_div, 0);
    chk("R1 pulses", {pll_rst, dly_rst}, 0);
    rd(8'h00, d); chk("R1 rd 0x00", d, 8'h41);
    rd(8'h03, d); chk("R1 rd 0x03", d, 8'h0F);
    rd(8'h06, d); chk("R1 rd 0x06", d, 8'h1F);
  endtask

  task automatic t_shadow;
    logic [7:0] d;
    wr(8'h02, 8'h34);
    wr(8'h03, 8'hF2);
    wr(8'h01, 8'hFF);
    rd(8'h02, d); chk("R2 rd 0x02", d, 8'h34);
    rd(8'h03, d); chk("R7 rd 0x03", d, 8'h02);
    rd(8'h01, d); chk("R7 rd 0x01", d, 8'h37);
    chk("R2 fb_div held", fb_div, 12'hFFF);
    chk("R2 loop held", {pd_gain, post_div}, 0);
  endtask

  task automatic t_pll_commit;
    logic p1, d1, p2, d2;
    cmd(8'h50, p1, d1, p2, d2);
    chk("R3 pll pulse", p1, 1);
    chk("R3 pll pulse width", p2, 0);
    chk("R3 no dly pulse", {d1, d2}, 0);
    chk("R12 fb_div", fb_div, 12'h234);
    chk("R3 pd_gain", pd_gain, 7);
    chk("R3 post_div", post_div, 3);
    chk("R3 dly_res untouched", dly_res, 3);
  endtask

  task automatic t_dly_commit;
    logic p1, d1, p2, d2;
    logic [7:0] d;
    wr(8'h05, 8'hFE);
    rd(8'h05, d); chk("R7 rd 0x05", d, 8'h02);
    chk("R2 dly_res held", dly_res, 3);
    cmd(8'h0A, p1, d1, p2, d2);
    chk("R4 dly pulse", d1, 1);
    chk("R4 dly pulse width", d2, 0);
    chk("R4 no pll pulse", {p1, p2}, 0);
    chk("R4 dly_res", dly_res, 2);
  endtask

  task automatic t_both;
    logic p1, d1, p2, d2;
    wr(8'h02, 8'h10);
    wr(8'h05, 8'h01);
    cmd(8'h5A, p1, d1, p2, d2);
    chk("R5 both pulses", {p1, d1}, 2'b11);
    chk("R5 both drop", {p2, d2}, 2'b00);
    chk("R5 fb_div", fb_div, 12'h210);
    chk("R5 dly_res", dly_res, 1);
    wr(8'h02, 8'h99);
    wr(8'h05, 8'h03);
    cmd(8'hA5, p1, d1, p2, d2);
    chk("R5 no pulse on 0xA5", {p1, d1, p2, d2}, 0);
    chk("R5 fb_div kept", fb_div, 12'h210);
    chk("R5 dly_res kept", dly_res, 1);
  endtask

  task automatic t_direct;
    logic [7:0] d;
    @(negedge clk); addr = 8'h06; wdata = 8'hE0; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk("R6 out_en", out_en, 0);
    chk("R6 clk_sel", clk_sel, 1);
    chk("R6 out_scale", out_scale, 3);
    wr(8'h00, 8'h00); chk("R6 ctrl", ctrl, 0);
    wr(8'h04, 8'hFF);
    chk("R6 phase_ofs", phase_ofs, 6'h3F);
    chk("R6 filt_int", filt_int, 1);
    rd(8'h04, d); chk("R7 rd 0x04", d, 8'hBF);
    wr(8'h07, 8'hFF);
    chk("R6 osc_div", osc_div, 7'h7F);
    rd(8'h07, d); chk("R7 rd 0x07", d, 8'h7F);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    pll_lock = 1'b0; dly_lock = 1'b1;
    rd(8'h12, d); chk("R8 dly lock", d, 8'h01);
    pll_lock = 1'b1; dly_lock = 1'b0;
    rd(8'h12, d); chk("R8 pll lock", d, 8'h02);
  endtask

  task automatic t_ids;
    logic [7:0] d;
    rd(8'h10, d); chk("R9 version", d, 8'hA7);
    rd(8'h11, d); chk("R9 revision", d, 8'h3C);
    wr(8'h10, 8'h00);
    rd(8'h10, d); chk("R9 version after write", d, 8'hA7);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(8'h09, 8'hFF);
    rd(8'h09, d); chk("R10 rd 0x09", d, 0);
    rd(8'h08, d); chk("R10 rd 0x08", d, 0);
    wr(8'h20, 8'h55);
    wr(8'h80, 8'h55);
    rd(8'h00, d); chk("R10 0x00 untouched", d, 8'h00);
    rd(8'h06, d); chk("R10 0x06 untouched", d, 8'hE0);
    chk("R10 ctrl untouched", ctrl, 0);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    rd(8'h11, d);
    pll_lock = 1'b0; dly_lock = 1'b1;
    addr = 8'h12;
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, 8'h3C);
    rd(8'h12, d); chk("R11 update", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_pll_commit();
    t_dly_commit();
    t_both();
    t_direct();
    t_lock();
    t_ids();
    t_unmapped();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule